// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the bus-facing storage of an interrupt distributor serving 128 interrupt lines and up to 8 CPU interfaces. A single-cycle, word-addressed bus with separate read and write strobes reaches it. Each access carries the index of the CPU that issues it. The bank holds the global distributor enable, one enable bit, one pending bit and one trigger-mode bit per interrupt, and one priority byte per interrupt.

Interrupts 0 to 31 are private. Each CPU index owns its own copy of their enable, pending and trigger bits. Interrupts 32 and up are shared by all CPUs. Enable and pending bits are changed through paired windows: one window sets bits and the other clears them. Both windows of a pair read back the same bit array. The enable, pending and edge vectors and the global enable leave the block as plain outputs for the routing and pending-signal logic. A one-cycle change pulse tells that logic to re-evaluate.

Top module: `dist_regbank`

## Requirements
- R1: The control word (word address 0x000) holds the global enable in bit 0. The bit reads back as written, drives `distEnable` from the cycle after the write, and resets to 0.
- R2: Word 0x001 is read-only. It returns `cpuCount`−1 in bits [7:5] and (128/32)−1 = 3 in bits [4:0], so the value is 0x63 when `cpuCount` is 4.
- R3: The set-enable window (words 0x040–0x043) and the clear-enable window (words 0x060–0x063) both read the current enable bits. In each written word, a 1 sets the bit through the first window and clears it through the second. A 0 leaves the bit unchanged. Word n covers interrupts 32n to 32n+31.
- R4: The set-pending window (0x080–0x083) and the clear-pending window (0x0A0–0x0A3) follow the same rules as R3, acting on the pending bits.
- R5: The enable bits of interrupts 0–15 are 1 after reset for every CPU. A write to clear-enable word 0 cannot clear them.
- R6: Word 0 of the enable and pending windows is banked by the requesting CPU index, and so is trigger-mode word 1 (interrupts 16–31). One CPU's accesses never change another CPU's copy.
- R7: Priority words 0x100–0x11F are read/write. Each word holds four 8-bit priorities, with the lowest-numbered interrupt in bits [7:0].
- R8: Trigger-mode words 0x300–0x307 give two bits per interrupt, interrupt k of the word at bits [2k+1:2k]. Only the upper bit is stored (1 = edge), and the lower bit reads 0. Writes to word 0x300 are ignored, and that word always reads 0xAAAAAAAA. The stored bits drive `edgePrivate` and `edgeShared`.
- R9: The group window (0x020–0x03F), the two active-state windows (0x0C0–0x0FF) and every other unmapped word read 0 and ignore writes.
- R10: Read data appears on `busRdata` in the cycle after the read strobe and is 0 in any cycle that follows no read.
- R11: `stateChanged` is high for exactly one cycle after a write that changes the control bit, an enable bit or a pending bit. It stays low after writes that change none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Write strobe |
| busRead | input | 1 | Read strobe |
| busWordAddr | input | 10 | Word address (byte offset / 4) |
| busCpu | input | 3 | Index of the requesting CPU |
| busWdata | input | 32 | Write data |
| cpuCount | input | 4 | Number of active CPUs (1 to 8) |
| busRdata | output | 32 | Registered read data |
| distEnable | output | 1 | Global distributor enable |
| enPrivate | output | 256 | Private enable bits, 32 per CPU, CPU c at [32c+31:32c] |
| enShared | output | 96 | Enable bits of interrupts 32–127 |
| pendPrivate | output | 256 | Private pending bits, 32 per CPU |
| pendShared | output | 96 | Pending bits of interrupts 32–127 |
| edgePrivate | output | 256 | Private edge bits, 32 per CPU |
| edgeShared | output | 96 | Edge bits of interrupts 32–127 |
| stateChanged | output | 1 | One-cycle pulse after a state-changing write |

## Verification
A corrupted stored bit shows on the flat output vectors in the cycle after the write that caused it. The same bit shows on `busRdata` one cycle after any read of its word, in both windows of its pair. A banking error is the hardest to see. It only appears when a second CPU index reads the word, so the checks read private words back under a different CPU index from the one that wrote them. A wrong change pulse is visible in the cycle right after the write and gone one cycle later, so the pulse is sampled in exactly that cycle.

// File: rtl/dist_pkg.sv
package dist_pkg;

  typedef enum logic [3:0] {
    K_NONE, K_CTL, K_TYPE, K_SETEN, K_CLREN, K_SETPD, K_CLRPD, K_PRIO, K_CFG
  } regKind_e;

  // Decoded access handed from the decoder to the storage
  typedef struct packed {
    logic     wr;
    logic     rd;
    regKind_e kind;
    logic [7:0] idx;   // word index inside the selected window
  } regStrobe_t;

endpackage

// File: rtl/dist_decode.sv
module dist_decode
  import dist_pkg::*;
#(
  parameter int NUM_IRQ = 128
) (
  input  logic       busWrite,
  input  logic       busRead,
  input  logic [9:0] busWordAddr,
  output regStrobe_t strb
);
  localparam int BIT_WORDS  = NUM_IRQ / 32;
  localparam int PRIO_WORDS = NUM_IRQ / 4;
  localparam int CFG_WORDS  = NUM_IRQ / 16;
  localparam logic [9:0] PRIO_BASE = 10'h100;
  localparam logic [9:0] CFG_BASE  = 10'h300;

  logic [4:0] region;
  logic [4:0] offs;

  always_comb begin
    region    = busWordAddr[9:5];
    offs      = busWordAddr[4:0];
    strb.wr   = busWrite;
    strb.rd   = busRead;
    strb.kind = K_NONE;
    strb.idx  = '0;
    if (busWordAddr == 10'h000) begin
      strb.kind = K_CTL;
    end else if (busWordAddr == 10'h001) begin
      strb.kind = K_TYPE;
    end else if (region >= 5'd2 && region <= 5'd5 && int'(offs) < BIT_WORDS) begin
      strb.idx = {3'b000, offs};
      case (region)
        5'd2:    strb.kind = K_SETEN;
        5'd3:    strb.kind = K_CLREN;
        5'd4:    strb.kind = K_SETPD;
        default: strb.kind = K_CLRPD;
      endcase
    end else if (busWordAddr >= PRIO_BASE && int'(busWordAddr) < int'(PRIO_BASE) + PRIO_WORDS) begin
      strb.kind = K_PRIO;
      strb.idx  = 8'(busWordAddr - PRIO_BASE);
    end else if (busWordAddr >= CFG_BASE && int'(busWordAddr) < int'(CFG_BASE) + CFG_WORDS) begin
      strb.kind = K_CFG;
      strb.idx  = 8'(busWordAddr - CFG_BASE);
    end
  end
endmodule

// File: rtl/dist_store.sv
module dist_store
  import dist_pkg::*;
#(
  parameter int NUM_IRQ = 128,
  parameter int NUM_CPU = 8
) (
  input  logic clk,
  input  logic rstN,
  input  regStrobe_t strb,
  input  logic [((NUM_CPU > 1) ? $clog2(NUM_CPU) : 1)-1:0] busCpu,
  input  logic [31:0] busWdata,
  input  logic [((NUM_CPU > 1) ? $clog2(NUM_CPU) : 1):0] cpuCount,
  output logic [31:0] busRdata,
  output logic distEnable,
  output logic [NUM_CPU*32-1:0] enPrivate,
  output logic [NUM_IRQ-33:0]   enShared,
  output logic [NUM_CPU*32-1:0] pendPrivate,
  output logic [NUM_IRQ-33:0]   pendShared,
  output logic [NUM_CPU*32-1:0] edgePrivate,
  output logic [NUM_IRQ-33:0]   edgeShared,
  output logic stateChanged
);
  localparam int SH = NUM_IRQ - 32;

  logic        distEnQ;
  logic [31:0] enPrivQ   [NUM_CPU];
  logic [31:0] pendPrivQ [NUM_CPU];
  logic [15:0] cfgPrivQ  [NUM_CPU];
  logic [SH-1:0] enShQ, pendShQ, cfgShQ;
  logic [7:0]  prioQ [NUM_IRQ];

  int          wIdx;
  logic        isEn, isPd, isBit, isSet;
  logic [31:0] oldWord, newWord, readWord;
  logic [15:0] cfgSrc;
  logic        bitChange, ctlChange;

  // Read-modify view of the addressed enable/pending word
  always_comb begin
    wIdx  = int'(strb.idx);
    isEn  = (strb.kind == K_SETEN) || (strb.kind == K_CLREN);
    isPd  = (strb.kind == K_SETPD) || (strb.kind == K_CLRPD);
    isBit = isEn || isPd;
    isSet = (strb.kind == K_SETEN) || (strb.kind == K_SETPD);
    oldWord = '0;
    if (isBit) begin
      if (wIdx == 0) oldWord = isPd ? pendPrivQ[busCpu] : enPrivQ[busCpu];
      else           oldWord = isPd ? pendShQ[(wIdx-1)*32 +: 32] : enShQ[(wIdx-1)*32 +: 32];
    end
    newWord = isSet ? (oldWord | busWdata) : (oldWord & ~busWdata);
    if (strb.kind == K_CLREN && wIdx == 0) newWord[15:0] = '1;
    bitChange = strb.wr && isBit && (newWord != oldWord);
    ctlChange = strb.wr && (strb.kind == K_CTL) && (busWdata[0] != distEnQ);
  end

  // Read multiplexer
  always_comb begin
    readWord = '0;
    cfgSrc   = '0;
    case (strb.kind)
      K_CTL:  readWord[0] = distEnQ;
      K_TYPE: begin
        readWord[7:5] = 3'(cpuCount - 1'b1);
        readWord[4:0] = 5'(NUM_IRQ / 32 - 1);
      end
      K_SETEN, K_CLREN, K_SETPD, K_CLRPD: readWord = oldWord;
      K_PRIO: for (int b = 0; b < 4; b++) readWord[8*b +: 8] = prioQ[wIdx*4 + b];
      K_CFG: begin
        if (wIdx == 0)      cfgSrc = '1;
        else if (wIdx == 1) cfgSrc = cfgPrivQ[busCpu];
        else                cfgSrc = cfgShQ[(wIdx-2)*16 +: 16];
        for (int i = 0; i < 16; i++) readWord[2*i+1] = cfgSrc[i];
      end
      default: readWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata     <= '0;
      stateChanged <= 1'b0;
      distEnQ      <= 1'b0;
      enShQ        <= '0;
      pendShQ      <= '0;
      cfgShQ       <= '0;
      for (int c = 0; c < NUM_CPU; c++) begin
        enPrivQ[c]   <= 32'h0000_FFFF;
        pendPrivQ[c] <= '0;
        cfgPrivQ[c]  <= '0;
      end
      for (int p = 0; p < NUM_IRQ; p++) prioQ[p] <= '0;
    end else begin
      busRdata     <= strb.rd ? readWord : '0;
      stateChanged <= bitChange || ctlChange;
      if (strb.wr) begin
        if (strb.kind == K_CTL) distEnQ <= busWdata[0];
        if (isEn) begin
          if (wIdx == 0) enPrivQ[busCpu] <= newWord;
          else           enShQ[(wIdx-1)*32 +: 32] <= newWord;
        end
        if (isPd) begin
          if (wIdx == 0) pendPrivQ[busCpu] <= newWord;
          else           pendShQ[(wIdx-1)*32 +: 32] <= newWord;
        end
        if (strb.kind == K_PRIO)
          for (int b = 0; b < 4; b++) prioQ[wIdx*4 + b] <= busWdata[8*b +: 8];
        if (strb.kind == K_CFG) begin
          for (int i = 0; i < 16; i++) begin
            if (wIdx == 1)      cfgPrivQ[busCpu][i] <= busWdata[2*i+1];
            else if (wIdx >= 2) cfgShQ[(wIdx-2)*16 + i] <= busWdata[2*i+1];
          end
        end
      end
    end
  end

  assign distEnable = distEnQ;
  assign enShared   = enShQ;
  assign pendShared = pendShQ;
  assign edgeShared = cfgShQ;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign enPrivate[c*32 +: 32]   = enPrivQ[c];
    assign pendPrivate[c*32 +: 32] = pendPrivQ[c];
    assign edgePrivate[c*32 +: 32] = {cfgPrivQ[c], 16'hFFFF};
  end
endmodule

// File: rtl/dist_regbank.sv
module dist_regbank
  import dist_pkg::*;
#(
  parameter int NUM_IRQ = 128,
  parameter int NUM_CPU = 8,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrite,
  input  logic                  busRead,
  input  logic [9:0]            busWordAddr,
  input  logic [CPU_W-1:0]      busCpu,
  input  logic [31:0]           busWdata,
  input  logic [CPU_W:0]        cpuCount,
  output logic [31:0]           busRdata,
  output logic                  distEnable,
  output logic [NUM_CPU*32-1:0] enPrivate,
  output logic [NUM_IRQ-33:0]   enShared,
  output logic [NUM_CPU*32-1:0] pendPrivate,
  output logic [NUM_IRQ-33:0]   pendShared,
  output logic [NUM_CPU*32-1:0] edgePrivate,
  output logic [NUM_IRQ-33:0]   edgeShared,
  output logic                  stateChanged
);
  regStrobe_t strb;

  dist_decode #(.NUM_IRQ(NUM_IRQ)) u_decode (
    .busWrite(busWrite), .busRead(busRead), .busWordAddr(busWordAddr), .strb(strb)
  );

  dist_store #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .busCpu(busCpu), .busWdata(busWdata),
    .cpuCount(cpuCount), .busRdata(busRdata), .distEnable(distEnable),
    .enPrivate(enPrivate), .enShared(enShared), .pendPrivate(pendPrivate),
    .pendShared(pendShared), .edgePrivate(edgePrivate), .edgeShared(edgeShared),
    .stateChanged(stateChanged)
  );
endmodule

// File: rtl/dist_regbank_chk.sv
module dist_regbank_chk #(
  parameter int NUM_IRQ = 128,
  parameter int NUM_CPU = 8
) (
  input logic clk,
  input logic rstN,
  input logic busWrite,
  input logic busRead,
  input logic [9:0] busWordAddr,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata,
  input logic distEnable,
  input logic [NUM_CPU*32-1:0] enPrivate,
  input logic [NUM_IRQ-33:0] enShared,
  input logic [NUM_IRQ-33:0] pendShared,
  input logic [NUM_CPU*32-1:0] edgePrivate,
  input logic stateChanged
);
  AST_CTL_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busWordAddr == 10'h000) |=> (distEnable == $past(busWdata[0]))); // R1

  AST_EN_DROPS_ONLY_ON_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrite && busWordAddr[9:5] == 5'd3) |=> ((enShared & $past(enShared)) == $past(enShared))); // R3

  AST_PEND_DROPS_ONLY_ON_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrite && busWordAddr[9:5] == 5'd5) |=> ((pendShared & $past(pendShared)) == $past(pendShared))); // R4

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_priv
    AST_SGI_EN_HELD: assert property (@(posedge clk) disable iff (!rstN)
      enPrivate[c*32 +: 16] == 16'hFFFF); // R5
    AST_SGI_EDGE_HELD: assert property (@(posedge clk) disable iff (!rstN)
      edgePrivate[c*32 +: 16] == 16'hFFFF); // R8
  end

  AST_RAZ_WINDOWS: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && (busWordAddr[9:5] == 5'd1 || busWordAddr[9:5] == 5'd6 || busWordAddr[9:5] == 5'd7))
    |=> (busRdata == 32'h0)); // R9

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busRead |=> (busRdata == 32'h0)); // R10

  AST_CHG_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    stateChanged |-> $past(busWrite)); // R11
endmodule

bind dist_regbank dist_regbank_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead),
  .busWordAddr(busWordAddr), .busWdata(busWdata), .busRdata(busRdata),
  .distEnable(distEnable), .enPrivate(enPrivate), .enShared(enShared),
  .pendShared(pendShared), .edgePrivate(edgePrivate), .stateChanged(stateChanged)
);

// File: tb/dist_regbank_tb.sv
module dist_regbank_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrite = 1'b0, busRead = 1'b0;
  logic [9:0] busWordAddr = '0;
  logic [2:0] busCpu = '0;
  logic [31:0] busWdata = '0;
  logic [3:0] cpuCount = 4'd4;
  logic [31:0] busRdata;
  logic distEnable, stateChanged;
  logic [255:0] enPrivate, pendPrivate, edgePrivate;
  logic [95:0] enShared, pendShared, edgeShared;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  dist_regbank u_dut (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead),
    .busWordAddr(busWordAddr), .busCpu(busCpu), .busWdata(busWdata),
    .cpuCount(cpuCount), .busRdata(busRdata), .distEnable(distEnable),
    .enPrivate(enPrivate), .enShared(enShared), .pendPrivate(pendPrivate),
    .pendShared(pendShared), .edgePrivate(edgePrivate), .edgeShared(edgeShared),
    .stateChanged(stateChanged)
  );

  typedef struct packed {
    logic        isRd;
    logic [9:0]  addr;
    logic [2:0]  cpu;
    logic [31:0] data;   // write data, or expected read value
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'h000, 3'd0, 32'h0000_0001, 8'd1},  // R1
    '{1'b1, 10'h000, 3'd0, 32'h0000_0001, 8'd1},  // R1
    '{1'b1, 10'h001, 3'd0, 32'h0000_0063, 8'd2},  // R2
    '{1'b0, 10'h041, 3'd0, 32'h0000_00F0, 8'd3},  // R3
    '{1'b1, 10'h041, 3'd0, 32'h0000_00F0, 8'd3},  // R3
    '{1'b1, 10'h061, 3'd0, 32'h0000_00F0, 8'd3},  // R3
    '{1'b0, 10'h061, 3'd0, 32'h0000_0030, 8'd3},  // R3
    '{1'b1, 10'h041, 3'd0, 32'h0000_00C0, 8'd3},  // R3
    '{1'b0, 10'h040, 3'd1, 32'hFF00_0000, 8'd6},  // R6
    '{1'b1, 10'h040, 3'd1, 32'hFF00_FFFF, 8'd6},  // R6
    '{1'b1, 10'h040, 3'd0, 32'h0000_FFFF, 8'd6},  // R6
    '{1'b0, 10'h060, 3'd1, 32'hFFFF_FFFF, 8'd5},  // R5
    '{1'b1, 10'h040, 3'd1, 32'h0000_FFFF, 8'd5},  // R5
    '{1'b0, 10'h082, 3'd0, 32'h8000_0001, 8'd4},  // R4
    '{1'b0, 10'h0A2, 3'd0, 32'h0000_0001, 8'd4},  // R4
    '{1'b1, 10'h082, 3'd0, 32'h8000_0000, 8'd4},  // R4
    '{1'b0, 10'h105, 3'd0, 32'h1122_3344, 8'd7},  // R7
    '{1'b1, 10'h105, 3'd0, 32'h1122_3344, 8'd7},  // R7
    '{1'b1, 10'h104, 3'd0, 32'h0000_0000, 8'd7},  // R7
    '{1'b0, 10'h300, 3'd0, 32'hFFFF_FFFF, 8'd8},  // R8
    '{1'b1, 10'h300, 3'd0, 32'hAAAA_AAAA, 8'd8},  // R8
    '{1'b0, 10'h302, 3'd0, 32'hFFFF_FFFF, 8'd8},  // R8
    '{1'b1, 10'h302, 3'd0, 32'hAAAA_AAAA, 8'd8},  // R8
    '{1'b0, 10'h303, 3'd0, 32'h0000_0003, 8'd8},  // R8
    '{1'b1, 10'h303, 3'd0, 32'h0000_0002, 8'd8},  // R8
    '{1'b0, 10'h301, 3'd2, 32'h8000_0000, 8'd6},  // R6
    '{1'b1, 10'h301, 3'd2, 32'h8000_0000, 8'd6},  // R6
    '{1'b1, 10'h301, 3'd0, 32'h0000_0000, 8'd6},  // R6
    '{1'b0, 10'h020, 3'd0, 32'hFFFF_FFFF, 8'd9},  // R9
    '{1'b1, 10'h020, 3'd0, 32'h0000_0000, 8'd9},  // R9
    '{1'b0, 10'h0C1, 3'd0, 32'hFFFF_FFFF, 8'd9},  // R9
    '{1'b1, 10'h0C1, 3'd0, 32'h0000_0000, 8'd9},  // R9
    '{1'b1, 10'h3FF, 3'd0, 32'h0000_0000, 8'd9}   // R9
  };

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Write: inputs held across one rising edge; returns at the next falling edge
  task automatic doWrite(input logic [9:0] a, input logic [2:0] c, input logic [31:0] d);
    busWordAddr = a; busCpu = c; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  // Read: data registered at the edge, sampled at the following falling edge (R10)
  task automatic doRead(input logic [9:0] a, input logic [2:0] c, output logic [31:0] d);
    busWordAddr = a; busCpu = c; busRead = 1'b1;
    @(negedge clk);
    busRead = 1'b0;
    d = busRdata;
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // reset state
    check("R1 reset enable", 256'(distEnable), 256'(0));
    check("R5 reset private enables", 256'(enPrivate), {8{32'h0000_FFFF}});
    check("R4 reset pending", 256'(pendShared), 256'(0));
    check("R8 reset edge", 256'(edgeShared), 256'(0));
    check("R10 reset read data", 256'(busRdata), 256'(0));
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isRd) begin
        doRead(VECS[i].addr, VECS[i].cpu, rd);
        check($sformatf("R%0d table row %0d", VECS[i].req, i), 256'(rd), 256'(VECS[i].data));
      end else begin
        doWrite(VECS[i].addr, VECS[i].cpu, VECS[i].data);
      end
    end

    // exported vectors after the table
    check("R1 distEnable out", 256'(distEnable), 256'(1));
    check("R3 enShared bits", 256'(enShared[7:0]), 256'(8'hC0));
    check("R4 pendShared irq95", 256'(pendShared[63:31]), 256'(33'h1_0000_0000));
    check("R8 edgeShared word2", 256'(edgeShared[15:0]), 256'(16'hFFFF));
    check("R8 edgeShared word3", 256'(edgeShared[17:16]), 256'(2'b01));
    check("R6 edgePrivate cpu2", 256'(edgePrivate[95:64]), 256'(32'h8000_FFFF));
    check("R6 edgePrivate cpu0", 256'(edgePrivate[31:0]), 256'(32'h0000_FFFF));

    // R10: nothing before the edge, then data, then back to zero
    busWordAddr = 10'h001; busRead = 1'b1;
    #1 check("R10 no early data", 256'(busRdata), 256'(0));
    @(negedge clk); busRead = 1'b0;
    check("R10 data after one edge", 256'(busRdata), 256'(32'h63));
    @(negedge clk);
    check("R10 cleared when idle", 256'(busRdata), 256'(0));

    // R11: change pulse
    doWrite(10'h000, 3'd0, 32'h1);
    check("R11 no pulse on same ctl", 256'(stateChanged), 256'(0));
    doWrite(10'h000, 3'd0, 32'h0);
    check("R11 pulse on ctl change", 256'(stateChanged), 256'(1));
    @(negedge clk);
    check("R11 pulse one cycle", 256'(stateChanged), 256'(0));
    check("R1 enable cleared", 256'(distEnable), 256'(0));
    doWrite(10'h041, 3'd0, 32'h80);
    check("R11 no pulse on set of set bit", 256'(stateChanged), 256'(0));
    doWrite(10'h106, 3'd0, 32'hFFFF_FFFF);
    check("R11 no pulse on priority", 256'(stateChanged), 256'(0));
    doWrite(10'h0A2, 3'd0, 32'h8000_0000);
    check("R11 pulse on pending clear", 256'(stateChanged), 256'(1));
    check("R4 pending cleared", 256'(pendShared[63]), 256'(0));
    doWrite(10'h060, 3'd3, 32'h0000_FFFF);
    check("R5 no pulse on forced SGI clear", 256'(stateChanged), 256'(0));
    check("R5 cpu3 SGI enables kept", 256'(enPrivate[127:96]), 256'(32'h0000_FFFF));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule